// File: doc/BRIEF.md
# Guarded System-Clock Control Register

This block is a single byte-wide control register for a clock generator. It holds three settings. The first is a three-bit code that picks the multiplication factor of the system clock. The second is a flag that says whether the oscillator input comes from an external clock or from a resonator. The third is a bit that picks the period of a time-base tick.

Every bus write is screened before the multiplier field may change. Codes outside the four legal ones are refused. Any change is refused while the chip runs in direct mode. A jump from one non-unity factor to another is also refused; software must go through the unity code between the two. A refused multiplier write raises a sticky error flag, and the other fields of the same write still take effect.

A free-running 9-bit counter advances on each enable of the raw oscillator. It emits a one-cycle tick every 256 or every 512 enables.

Top module: `clk_select_guard`

## Requirements
- R1: After reset the register reads 0x00, and the multiplier code, external flag, feedback-off flag, error flag and tick are all 0.
- R2: In the read value, bits 7, 6 and 3 are always 0. Bit 5 is the tick select, bit 4 is the external flag, and bits 2:0 are the multiplier code.
- R3: With `directMode` low, a write of a legal code (000 = x1, 001 = x2.5, 011 = x5, 111 = x10) from code 000 is stored and appears on `mulCode` the next cycle.
- R4: A write of any other multiplier code (010, 100, 101, 110) leaves the code unchanged and sets `errFlag`.
- R5: With `directMode` high, a write that would change the multiplier code is refused and sets `errFlag`. A write that repeats the current code raises no error.
- R6: A write that changes the code from one non-unity value to a different non-unity value is refused and sets `errFlag`. The same target is accepted once the code has first been set to 000.
- R7: Bits 5 and 4 are stored on every accepted bus write, including one whose multiplier part is refused.
- R8: `extClkMode` and `oscFeedbackOff` both follow stored bit 4.
- R9: `errFlag` stays set until an `errClr` pulse clears it. When a refused write and `errClr` occur in the same cycle, the flag ends up set.
- R10: A write with `busAddrHit` low changes nothing.
- R11: `tbTick` is a one-cycle pulse. It fires once every 256 `oscTickEn` cycles when the select is 0, and once every 512 when the select is 1.
- R12: A new tick select takes effect only when the full 9-bit counter wraps, so no interval between ticks is shorter than 256 enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Bus write strobe |
| busAddrHit | input | 1 | Address decode match for this register |
| busWrData | input | 8 | Write data byte |
| directMode | input | 1 | 1 = direct mode, 0 = PLL mode |
| oscTickEn | input | 1 | One-cycle enable per raw oscillator clock |
| errClr | input | 1 | Clears the sticky error flag |
| busRdData | output | 8 | Register read value |
| mulCode | output | 3 | Stored multiplier code |
| extClkMode | output | 1 | External clock drives the oscillator input |
| oscFeedbackOff | output | 1 | Oscillator feedback path disconnected |
| errFlag | output | 1 | Sticky flag for a refused multiplier write |
| tbTick | output | 1 | Time-base tick pulse |

## Verification
Some properties are checked on every cycle. The stored code is always one of the four legal values. It never changes in a cycle after direct mode was asserted. It never moves directly between two different non-unity codes. The error flag only rises after a refused write, and the tick never lasts two cycles.

Other behaviour only the bench scenarios can show. These include the exact tick periods and the point at which a new period select takes effect. They also include the survival of bits 5 and 4 on a refused write, the priority of set over clear, and the fact that writes without an address hit are ignored. The bench covers these by comparing every cycle against a behavioural model, with some stretches of irregular oscillator enables.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int REG_W = 8;
  localparam int MUL_W = 3;
  localparam int TB_SEL_BIT = 5;
  localparam int EXT_BIT = 4;
  localparam int TB_LOW_W = 8;
  localparam int TB_W = TB_LOW_W + 1;

  typedef struct packed {
    logic loadMisc;
    logic loadMul;
    logic setErr;
    logic clrErr;
  } ctlStrobes_t;

  function automatic logic isLegalMul(input logic [MUL_W-1:0] code);
    return (code == 3'b000) || (code == 3'b001) || (code == 3'b011) || (code == 3'b111);
  endfunction
endpackage

// File: rtl/ckg_ctl.sv
module ckg_ctl
  import ckg_pkg::*;
(
  input  logic             wrValid,
  input  logic [MUL_W-1:0] wrMul,
  input  logic [MUL_W-1:0] curMul,
  input  logic             directMode,
  input  logic             errClr,
  output ctlStrobes_t      strobes
);
  logic mulChange;
  logic viaUnity;
  logic accept;

  always_comb begin
    mulChange = (wrMul != curMul);
    viaUnity  = (curMul == '0) || (wrMul == '0);
    accept    = !directMode && isLegalMul(wrMul) && viaUnity;
    strobes.loadMisc = wrValid;
    strobes.loadMul  = wrValid && mulChange && accept;
    strobes.setErr   = wrValid && mulChange && !accept;
    strobes.clrErr   = errClr;
  end
endmodule

// File: rtl/ckg_dp.sv
module ckg_dp
  import ckg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic             directMode,
  input  logic             oscTickEn,
  output logic [MUL_W-1:0] mulReg,
  output logic             extReg,
  output logic             tbSelReg,
  output logic             errFlag,
  output logic             tbTick
);
  localparam logic [TB_W-1:0] FULL_WRAP = '1;
  localparam logic [TB_LOW_W-1:0] LOW_WRAP = '1;

  logic [TB_W-1:0] tbCnt;
  logic tbSelActive;
  logic lowWrap;
  logic fullWrap;
  logic tickHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulReg   <= '0;
      extReg   <= 1'b0;
      tbSelReg <= 1'b0;
    end else begin
      if (strobes.loadMul) mulReg <= wrData[MUL_W-1:0];
      if (strobes.loadMisc) begin
        extReg   <= wrData[EXT_BIT];
        tbSelReg <= wrData[TB_SEL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (strobes.setErr) errFlag <= 1'b1;
    else if (strobes.clrErr) errFlag <= 1'b0;
  end

  always_comb begin
    lowWrap  = (tbCnt[TB_LOW_W-1:0] == LOW_WRAP);
    fullWrap = (tbCnt == FULL_WRAP);
    tickHit  = oscTickEn && (tbSelActive ? fullWrap : lowWrap);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbCnt       <= '0;
      tbSelActive <= 1'b0;
      tbTick      <= 1'b0;
    end else begin
      tbTick <= tickHit;
      if (oscTickEn) begin
        tbCnt <= tbCnt + 1'b1;
        if (fullWrap) tbSelActive <= tbSelReg;
      end
    end
  end

  // R3 R4
  mul_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    isLegalMul(mulReg));
  // R5
  direct_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mulReg != $past(mulReg)) |-> !$past(directMode));
  // R6
  unity_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mulReg) != '0 && mulReg != '0) |-> (mulReg == $past(mulReg)));
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(strobes.setErr));
  // R11
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tbTick |=> !tbTick);
endmodule

// File: rtl/clk_select_guard.sv
module clk_select_guard
  import ckg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busAddrHit,
  input  logic [REG_W-1:0] busWrData,
  input  logic             directMode,
  input  logic             oscTickEn,
  input  logic             errClr,
  output logic [REG_W-1:0] busRdData,
  output logic [MUL_W-1:0] mulCode,
  output logic             extClkMode,
  output logic             oscFeedbackOff,
  output logic             errFlag,
  output logic             tbTick
);
  ctlStrobes_t strobes;
  logic extReg;
  logic tbSelReg;

  ckg_ctl ctl_i (
    .wrValid   (busWrEn && busAddrHit),
    .wrMul     (busWrData[MUL_W-1:0]),
    .curMul    (mulCode),
    .directMode(directMode),
    .errClr    (errClr),
    .strobes   (strobes)
  );

  ckg_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (busWrData),
    .directMode(directMode),
    .oscTickEn (oscTickEn),
    .mulReg    (mulCode),
    .extReg    (extReg),
    .tbSelReg  (tbSelReg),
    .errFlag   (errFlag),
    .tbTick    (tbTick)
  );

  always_comb begin
    busRdData = '0;
    busRdData[MUL_W-1:0]  = mulCode;
    busRdData[EXT_BIT]    = extReg;
    busRdData[TB_SEL_BIT] = tbSelReg;
    extClkMode     = extReg;
    oscFeedbackOff = extReg;
  end
endmodule

// File: tb/clk_select_guard_tb.sv
module clk_select_guard_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busAddrHit = 1'b0, directMode = 1'b0, oscTickEn = 1'b0, errClr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [2:0] mulCode;
  logic extClkMode, oscFeedbackOff, errFlag, tbTick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastTick = -1;
  int minGap = 100000;
  int lastGap = 0;
  bit done = 0;

  // behavioural reference state
  int mMul = 0, mExt = 0, mSel = 0, mAct = 0, mErr = 0, mCnt = 0, mTick = 0;

  always #2 clk = ~clk;

  clk_select_guard dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddrHit(busAddrHit),
    .busWrData(busWrData), .directMode(directMode), .oscTickEn(oscTickEn),
    .errClr(errClr), .busRdData(busRdData), .mulCode(mulCode),
    .extClkMode(extClkMode), .oscFeedbackOff(oscFeedbackOff),
    .errFlag(errFlag), .tbTick(tbTick)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit legal(int c);
    return c == 0 || c == 1 || c == 3 || c == 7;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMul = 0; mExt = 0; mSel = 0; mAct = 0; mErr = 0; mCnt = 0; mTick = 0;
    end else begin
      bit errSet;
      int nm;
      mTick = 0;
      if (oscTickEn) begin
        if (mAct ? (mCnt == 511) : (mCnt % 256 == 255)) mTick = 1;
        if (mCnt == 511) mAct = mSel;
        mCnt = (mCnt + 1) % 512;
      end
      errSet = 0;
      if (busWrEn && busAddrHit) begin
        nm = busWrData & 7;
        if (nm != mMul) begin
          if (!directMode && legal(nm) && (mMul == 0 || nm == 0)) mMul = nm;
          else errSet = 1;
        end
        mSel = busWrData[5];
        mExt = busWrData[4];
      end
      if (errSet) mErr = 1;
      else if (errClr) mErr = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      check("R2 read", busRdData, mSel * 32 + mExt * 16 + mMul);
      check("R3 mulCode", mulCode, mMul);
      check("R8 ext", extClkMode, mExt);
      check("R8 feedback", oscFeedbackOff, mExt);
      check("R9 err", errFlag, mErr);
      check("R11 R12 tick", tbTick, mTick);
      if (tbTick) begin
        if (lastTick >= 0) begin
          lastGap = cyc - lastTick;
          if (lastGap < minGap) minGap = lastGap;
        end
        lastTick = cyc;
      end
    end
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [7:0] d, logic hit = 1'b1, logic clr = 1'b0);
    @(negedge clk);
    busWrEn = 1'b1; busAddrHit = hit; busWrData = d; errClr = clr;
    @(negedge clk);
    busWrEn = 1'b0; busAddrHit = 1'b0; errClr = 1'b0;
  endtask

  task automatic clearErr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 read", busRdData, 0);
    check("R1 err", errFlag, 0);
    check("R1 tick", tbTick, 0);
    rstN = 1'b1;
    wr(8'hFF);
    check("R2 masked read", busRdData, 8'h37);
    check("R3 x10", mulCode, 7);
    wr(8'h03);
    check("R6 jump refused", mulCode, 7);
    check("R6 err", errFlag, 1);
    clearErr();
    check("R9 cleared", errFlag, 0);
    wr(8'h00);
    wr(8'h03);
    check("R6 via unity", mulCode, 3);
    check("R6 no err", errFlag, 0);
    wr(8'h00);
    wr(8'h32);
    check("R4 prohibited", mulCode, 0);
    check("R4 err", errFlag, 1);
    check("R7 misc kept", busRdData, 8'h30);
    check("R8 ext set", extClkMode, 1);
    clearErr();
    wr(8'h01);
    check("R3 x2.5", mulCode, 1);
    @(negedge clk); directMode = 1'b1;
    wr(8'h01);
    check("R5 same code", errFlag, 0);
    wr(8'h00);
    check("R5 direct refused", mulCode, 1);
    check("R5 err", errFlag, 1);
    clearErr();
    wr(8'h00, 1'b1, 1'b1);
    check("R9 set wins", errFlag, 1);
    clearErr();
    wr(8'h10, 1'b0);
    check("R10 no hit", busRdData, 8'h01);
    @(negedge clk); directMode = 1'b0;
    wr(8'h00);
    // R11 period 256
    oscTickEn = 1'b1;
    lastTick = -1;
    repeat (1200) @(negedge clk);
    check("R11 gap 256", lastGap, 256);
    wr(8'h20);
    repeat (1600) @(negedge clk);
    check("R11 gap 512", lastGap, 512);
    wr(8'h00);
    repeat (1200) @(negedge clk);
    check("R12 back to 256", lastGap, 256);
    check("R12 min gap", minGap >= 256, 1);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      oscTickEn = ($urandom % 4) != 0;
      if (i % 1500 == 700) begin
        busWrEn = 1'b1; busAddrHit = 1'b1; busWrData = (i % 3000 == 700) ? 8'h20 : 8'h00;
      end else begin
        busWrEn = 1'b0; busAddrHit = 1'b0;
      end
    end
    busWrEn = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule